// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous, single-clock static memory model whose read and write commands can be issued on consecutive cycles in any mix, with no idle cycles between them. The block registers every command, address and byte-enable input on the rising edge that accepts it. A write supplies its data two accepted edges later. The write address and byte lanes travel down a two-stage pipeline so that they meet that data at the array. Read data comes out of an output register on the same two-edge schedule, so both directions keep the same pipeline depth and the bus never needs a turnaround gap.

An advance/load input chooses the address for each cycle. When it is low, the cycle loads a fresh external address. When it is high, a two-bit burst counter steps the previous address and repeats the previous command kind. Three chip-select inputs of mixed polarity decide whether a loaded cycle is a real access. A clock-enable input (active low) freezes the whole block. An asynchronous sleep input blocks accesses and releases the data bus. An output-enable input releases the bus without touching the pipeline. A read that reaches the array in the same cycle as an older write to the same address receives the new write bytes merged over the array word.

Top module: `zt_burst_sram`

## Requirements
- R1: The data for a read command appears on `qOut` with `qDrive` high after the second accepted rising edge that follows the edge that captured the command, and stays there until the next accepted edge.
- R2: A write command takes `dIn` on the second accepted edge after its own capture edge. Byte lane i is bits [9i+8:9i] of the data word and includes its parity bit. Lane i is written only when `byteWrN[i]` is 0. With all `byteWrN` bits at 1, the write changes no byte.
- R3: With `wrEnN` high, a loaded selected cycle is a read, and `byteWrN` has no effect on the array.
- R4: A loaded cycle is an access only when `selN1`=0, `sel2`=1 and `selN3`=0. Any other combination is idle: nothing is written, and `qDrive` stays low for that slot.
- R5: With `advLoad`=0 the cycle uses `addr`. With `advLoad`=1 it repeats the previous command kind (read, write or idle) at the previous address, with the low 2 bits incremented modulo 4 (3 wraps to 0) and the upper bits kept.
- R6: A read issued one cycle after a write to the same address returns that write's data, merged lane by lane over the older stored word.
- R7: While `clkEnN` is 1, no command is captured, the pipeline does not move, nothing is written, and `qOut`/`qDrive` hold their values.
- R8: `outEnN`=1 forces `qDrive` low at once. It does not disturb data that is in flight, which is driven again when `outEnN` returns to 0.
- R9: `sleep`=1 forces `qDrive` low at once, with no clock. Any command presented while `sleep` is 1 is treated as idle.
- R10: An active-low `rstN` clears the pipeline and the output-valid state, so `qDrive` is low. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low pipeline reset |
| clkEnN | input | 1 | Clock enable, active low; 1 stalls the block |
| sleep | input | 1 | Asynchronous low-power request, active high |
| advLoad | input | 1 | 1 = step the burst counter, 0 = load `addr` |
| addr | input | 6 | External word address |
| selN1 | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| selN3 | input | 1 | Chip select, active low |
| wrEnN | input | 1 | 0 = write, 1 = read |
| byteWrN | input | 2 | Per-lane write enables, active low |
| outEnN | input | 1 | Output enable, active low |
| dIn | input | 18 | Write data, taken two accepted edges after its command |
| qOut | output | 18 | Registered read data |
| qDrive | output | 1 | High when `qOut` is driving the bus; low means high impedance |

## Verification
The collision of interest is a read that captures the array in the same cycle as an older write commits to the same address. A write issued one slot before a read of the same word sets it up: the read then samples the array on the very edge at which the write lands. The bench provokes this once with a full-word write and once with a single-lane write over a known word. It judges the result by comparing `qOut` two slots later against the merged word, computed lane by lane. A second overlap comes from stalling with `clkEnN` while a read is in flight. The bench checks that the read emerges only after the required number of accepted edges.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int ADDR_W  = 6;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int BURST_W = 2;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic              adv;          // pipeline moves on this edge
    logic              rdCap;        // capture array word into read holding register
    logic [ADDR_W-1:0] rdAddr;       // address of command in stage 1
    logic              wrCommit;     // write lanes of stage 2 on this edge
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  wrLanes;
    logic              outValidNext; // stage 2 holds a read
  } strobe_t;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              advLoad,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN1,
  input  logic              sel2,
  input  logic              selN3,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  byteWrN,
  output strobe_t           stb
);
  op_e               s1Op, s2Op, lastOp, nextOp;
  logic [ADDR_W-1:0] s1Addr, s2Addr, nextAddr;
  logic [LANES-1:0]  s1Lanes, s2Lanes, nextLanes;
  logic              chipSel;

  assign chipSel = ~selN1 & sel2 & ~selN3;

  always_comb begin
    if (sleep)              nextOp = OP_IDLE;
    else if (advLoad)       nextOp = lastOp;
    else if (!chipSel)      nextOp = OP_IDLE;
    else if (wrEnN)         nextOp = OP_READ;
    else                    nextOp = OP_WRITE;
  end

  // Burst step: low bits wrap, upper bits kept
  always_comb begin
    if (advLoad)
      nextAddr = {s1Addr[ADDR_W-1:BURST_W], s1Addr[BURST_W-1:0] + BURST_W'(1)};
    else
      nextAddr = addr;
  end

  assign nextLanes = (nextOp == OP_WRITE) ? ~byteWrN : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op    <= OP_IDLE;
      s2Op    <= OP_IDLE;
      lastOp  <= OP_IDLE;
      s1Addr  <= '0;
      s2Addr  <= '0;
      s1Lanes <= '0;
      s2Lanes <= '0;
    end else if (!clkEnN) begin
      s1Op    <= nextOp;
      s1Lanes <= nextLanes;
      s2Op    <= s1Op;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
      if (!sleep) begin
        s1Addr <= nextAddr;
        lastOp <= nextOp;
      end
    end
  end

  always_comb begin
    stb.adv          = ~clkEnN;
    stb.rdCap        = ~clkEnN & (s1Op == OP_READ);
    stb.rdAddr       = s1Addr;
    stb.wrCommit     = ~clkEnN & ~sleep & (s2Op == OP_WRITE);
    stb.wrAddr       = s2Addr;
    stb.wrLanes      = s2Lanes;
    stb.outValidNext = (s2Op == OP_READ);
  end
endmodule

// File: rtl/zt_sram_data.sv
module zt_sram_data
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              outEnN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged, rdHold, qReg;
  logic              qValid;
  logic              sameWord;

  assign sameWord = stb.wrCommit && (stb.wrAddr == stb.rdAddr);

  // Forward lanes of a write that lands on the capture edge
  always_comb begin
    merged = mem[stb.rdAddr];
    for (int l = 0; l < LANES; l++) begin
      if (sameWord && stb.wrLanes[l])
        merged[l*LANE_W +: LANE_W] = dIn[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (stb.wrLanes[l])
          mem[stb.wrAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold <= '0;
      qReg   <= '0;
      qValid <= 1'b0;
    end else begin
      if (stb.rdCap) rdHold <= merged;
      if (stb.adv) begin
        qReg   <= rdHold;
        qValid <= stb.outValidNext;
      end
    end
  end

  assign qOut   = qReg;
  assign qDrive = qValid & ~outEnN & ~sleep;
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              advLoad,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN1,
  input  logic              sel2,
  input  logic              selN3,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive
);
  strobe_t stb;

  zt_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .advLoad(advLoad), .addr(addr), .selN1(selN1), .sel2(sel2),
    .selN3(selN3), .wrEnN(wrEnN), .byteWrN(byteWrN), .stb(stb)
  );

  zt_sram_data u_data (
    .clk(clk), .rstN(rstN), .sleep(sleep), .outEnN(outEnN),
    .stb(stb), .dIn(dIn), .qOut(qOut), .qDrive(qDrive)
  );
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              sleep,
  input logic              advLoad,
  input logic              selN1,
  input logic              sel2,
  input logic              selN3,
  input logic              wrEnN,
  input logic              outEnN,
  input logic [DATA_W-1:0] qOut,
  input logic              qDrive,
  input logic [ADDR_W-1:0] s1Addr
);
  logic [1:0] cyc;
  logic       selNow;

  assign selNow = ~selN1 & sel2 & ~selN3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R7: a stalled edge leaves the output register untouched
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(qOut));

  // R1: a loaded selected read, three unstalled edges back, is on the bus
  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && !$past(clkEnN, 3) && !$past(clkEnN, 2) && !$past(clkEnN, 1)
     && !$past(advLoad, 3) && $past(selNow, 3) && $past(wrEnN, 3)
     && !$past(sleep, 3) && !sleep && !outEnN) |-> qDrive);

  // R4: a loaded deselected slot never drives
  p_deselect_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && !$past(clkEnN, 3) && !$past(clkEnN, 2) && !$past(clkEnN, 1)
     && !$past(advLoad, 3) && !$past(selNow, 3)) |-> !qDrive);

  // R5: an advance steps the low address bits by one and keeps the rest
  p_burst_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLoad && !sleep) |=>
      (s1Addr[BURST_W-1:0] == $past(s1Addr[BURST_W-1:0]) + BURST_W'(1))
      && (s1Addr[ADDR_W-1:BURST_W] == $past(s1Addr[ADDR_W-1:BURST_W])));
endmodule

bind zt_burst_sram zt_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
  .advLoad(advLoad), .selN1(selN1), .sel2(sel2), .selN3(selN3),
  .wrEnN(wrEnN), .outEnN(outEnN), .qOut(qOut), .qDrive(qDrive),
  .s1Addr(stb.rdAddr)
);

// File: tb/zt_burst_sram_test.sv
module zt_burst_sram_test;
  import zt_sram_pkg::*;

  logic              clk = 1'b0;
  logic              rstN, clkEnN, sleep, advLoad, selN1, sel2, selN3, wrEnN, outEnN;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  byteWrN;
  logic [DATA_W-1:0] dIn, qOut;
  logic              qDrive;
  int                checks = 0;
  int                fails  = 0;
  logic              done   = 1'b0;

  always #2 clk = ~clk;

  zt_burst_sram uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .advLoad(advLoad),
    .addr(addr), .selN1(selN1), .sel2(sel2), .selN3(selN3), .wrEnN(wrEnN),
    .byteWrN(byteWrN), .outEnN(outEnN), .dIn(dIn), .qOut(qOut), .qDrive(qDrive)
  );

  // {adv, cs(selN1,sel2,selN3), wrEnN, byteWrN, addr, dIn, expDrive, expQ}
  localparam int NVEC = 18;
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 3'b010, 1'b0, 2'b00, 6'd4, 18'h00000, 1'b0, 18'h00000}, // 0 write 4 (R2)
    {1'b1, 3'b010, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b0, 18'h00000}, // 1 burst write 5 (R5)
    {1'b0, 3'b010, 1'b1, 2'b00, 6'd4, 18'h0AAAA, 1'b0, 18'h00000}, // 2 read 4, bw ignored (R3)
    {1'b1, 3'b010, 1'b1, 2'b00, 6'd0, 18'h15555, 1'b0, 18'h00000}, // 3 burst read 5
    {1'b0, 3'b010, 1'b0, 2'b10, 6'd4, 18'h00000, 1'b0, 18'h00000}, // 4 lane0-only write 4 (R2)
    {1'b0, 3'b010, 1'b1, 2'b11, 6'd4, 18'h00000, 1'b1, 18'h0AAAA}, // 5 read 4 right after (R6)
    {1'b0, 3'b110, 1'b1, 2'b11, 6'd0, 18'h3FFFF, 1'b1, 18'h15555}, // 6 idle selN1=1 (R4)
    {1'b0, 3'b010, 1'b0, 2'b11, 6'd5, 18'h00000, 1'b0, 18'h00000}, // 7 write no lanes (R2)
    {1'b0, 3'b010, 1'b1, 2'b11, 6'd5, 18'h00000, 1'b1, 18'h0ABFF}, // 8 read 5; sees merged (R6)
    {1'b0, 3'b010, 1'b0, 2'b00, 6'd7, 18'h3FFFF, 1'b0, 18'h00000}, // 9 write 7
    {1'b0, 3'b010, 1'b1, 2'b11, 6'd7, 18'h00000, 1'b0, 18'h00000}, // 10 read 7 (R6)
    {1'b1, 3'b010, 1'b1, 2'b11, 6'd0, 18'h2D2D2, 1'b1, 18'h15555}, // 11 advance wraps to 4 (R5)
    {1'b0, 3'b000, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b0, 18'h00000}, // 12 idle sel2=0 (R4)
    {1'b0, 3'b011, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b1, 18'h2D2D2}, // 13 idle selN3=1 (R4)
    {1'b0, 3'b010, 1'b1, 2'b00, 6'd5, 18'h00000, 1'b1, 18'h0ABFF}, // 14 read 5, bw low (R3)
    {1'b0, 3'b110, 1'b1, 2'b11, 6'd0, 18'h3FFFF, 1'b0, 18'h00000}, // 15
    {1'b0, 3'b110, 1'b1, 2'b11, 6'd0, 18'h3FFFF, 1'b0, 18'h00000}, // 16
    {1'b0, 3'b110, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b1, 18'h15555}  // 17
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCmd(input logic a, input logic [2:0] cs, input logic we,
                        input logic [1:0] bw, input logic [ADDR_W-1:0] ad);
    advLoad = a;
    {selN1, sel2, selN3} = cs;
    wrEnN   = we;
    byteWrN = bw;
    addr    = ad;
  endtask

  task automatic setIdle;
    setCmd(1'b0, 3'b110, 1'b1, 2'b11, '0);
  endtask

  task automatic checkDrive(input string req, input logic exp);
    checks++;
    if (qDrive !== exp) begin
      fails++;
      $display("FAIL %s qDrive=%0b expected %0b", req, qDrive, exp);
    end
  endtask

  task automatic checkData(input string req, input logic [DATA_W-1:0] exp);
    checks++;
    if (qDrive !== 1'b1 || qOut !== exp) begin
      fails++;
      $display("FAIL %s qDrive=%0b qOut=%h expected drive 1 data %h", req, qDrive, qOut, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; sleep = 1'b0; outEnN = 1'b0; dIn = '0;
    setIdle();
    repeat (3) @(negedge clk);
    checkDrive("R10 reset state", 1'b0);
    rstN = 1'b1;
    repeat (3) tick();

    // Vector walk: sample the slot of row i-3, then drive row i
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][18]) checkData($sformatf("R1 vector row %0d", i), VEC[i][17:0]);
      else            checkDrive($sformatf("R1 R4 vector row %0d", i), 1'b0);
      setCmd(VEC[i][49], VEC[i][48:46], VEC[i][45], VEC[i][44:43], VEC[i][42:37]);
      dIn = VEC[i][36:19];
      tick();
    end

    // R8: output enable releases the bus but keeps the data
    setCmd(1'b0, 3'b010, 1'b1, 2'b11, 6'd4);
    tick();
    setIdle();
    tick(); tick();
    outEnN = 1'b1;
    #1 checkDrive("R8 output enable high", 1'b0);
    outEnN = 1'b0;
    #1 checkData("R8 output enable low again", 18'h0ABFF);

    // R7: stall with a read in flight
    repeat (3) tick();
    setCmd(1'b0, 3'b010, 1'b1, 2'b11, 6'd5);
    tick();
    setIdle();
    clkEnN = 1'b1;
    repeat (5) tick();
    checkDrive("R7 stalled read not out", 1'b0);
    clkEnN = 1'b0;
    tick();
    checkDrive("R7 one accepted edge after stall", 1'b0);
    tick();
    checkData("R7 read after stall", 18'h15555);
    clkEnN = 1'b1;
    repeat (3) tick();
    checkData("R7 output held while stalled", 18'h15555);
    clkEnN = 1'b0;

    // R9: sleep releases the bus at once and blocks a write
    sleep = 1'b1;
    #1 checkDrive("R9 sleep drops drive", 1'b0);
    setCmd(1'b0, 3'b010, 1'b0, 2'b00, 6'd5);
    tick();
    setIdle();
    tick();
    dIn = '0;
    tick();
    sleep = 1'b0;
    tick();
    setCmd(1'b0, 3'b010, 1'b1, 2'b11, 6'd5);
    tick();
    setIdle();
    tick(); tick();
    checkData("R9 write during sleep ignored", 18'h15555);

    // R10: reset mid-run clears output valid
    rstN = 1'b0;
    #1 checkDrive("R10 reset clears drive", 1'b0);
    tick();
    rstN = 1'b1;
    tick();
    checkDrive("R10 after reset release", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule